// File: doc/BRIEF.md
# Error Reporting Decision Unit

This block decides, for one detected error inside a device, which status bits it sets and whether it sends an error message. The error arrives as a one-cycle strobe with a one-hot error code, a flag that marks it correctable, and a flag that marks an uncorrectable error as possibly advisory. The unit takes the current mask, severity, device-control and command enables from the register file that owns them. One cycle later it returns set-strobes for the device status, correctable status and uncorrectable status, a header-log request, and the message it produced with that message's severity.

The message is then taken through two stages. The first is the device's own system-error and device-control gating. The second is one hop through the upstream bridge or root port, which records a received system error and forwards the message only when the bridge allows it. A second lane runs in parallel with the first. If the header log is full when a log request is made, that lane handles the follow-up correctable header-log-overflow error in the same cycle.

Top module: `err_report_unit`

## Requirements
- R1: An error is accepted only if the code, after filtering to the supported set, has exactly one bit set. The supported uncorrectable positions are 0, 4, 5 and 12 to 25. The supported correctable positions are 0, 6, 7, 8 and 12 to 15. A rejected strobe, or no strobe, gives all-zero outputs. Results appear on the cycle after the strobe.
- R2: For an uncorrectable error, fatal severity comes from the severity input bit when `i_sev_src`=1 (bit set means fatal). When `i_sev_src`=0 a built-in default applies: positions 0, 4, 5, 13, 17 and 18 are fatal and all others are non-fatal.
- R3: A correctable error sets device status bit 0 (correctable detected) and its own correctable status bit. It produces a correctable message only if that bit is unmasked and `i_cor_en` is 1.
- R4: A non-fatal error with `i_adv`=1 is signalled as correctable. It sets device status bit 0, plus bit 3 if it is an unsupported request (position 20), and it sets correctable status bit 13. If bit 13 is masked, nothing else happens. Otherwise, when the uncorrectable mask bit is clear, the error also requests a log and sets its uncorrectable status bit. A correctable message then needs `i_cor_en`, and for an unsupported request it also needs `i_ur_en`.
- R5: Any other uncorrectable error sets device status bit 2 (fatal) or bit 1 (non-fatal), plus bit 3 for an unsupported request, and always sets its uncorrectable status bit. If it is masked, nothing else happens. Otherwise it requests a log.
- R6: An unmasked uncorrectable error gives a message as follows. A fatal message needs `i_serr_en` or `i_fatal_en`. A non-fatal message needs `i_serr_en` or `i_nf_en`. An unsupported request with both `i_ur_en` and `i_serr_en` clear gives no message. Severity codes are 1 for correctable, 2 for non-fatal and 3 for fatal; 0 means no message.
- R7: At the device stage, an uncorrectable message with `i_serr_en`=1 raises `o_sig_serr`. Such a message is then emitted only if its own device-control enable is set. All other messages are emitted unchanged.
- R8: Each emitted uncorrectable message raises `o_rcv_serr` at the bridge hop. An emitted message of any severity is forwarded only when `i_brg_serr_en`=1.
- R9: When a log request meets `i_log_full`=1, lane 1 handles a correctable error at position 15. That error sets device status bit 0 and correctable status bit 15. It goes through the R3, R7 and R8 rules and is reported on bit 1 of `o_msg_vld` and `o_fwd_vld` and on bits 3:2 of `o_msg_sev`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_inj | input | 1 | Error strobe |
| i_corr | input | 1 | Error is correctable |
| i_adv | input | 1 | Non-fatal error may be advisory |
| i_err | input | 26 | One-hot error code |
| i_sev_src | input | 1 | 1: severity from `i_unc_sev`, 0: built-in default |
| i_unc_mask | input | 26 | Uncorrectable mask |
| i_unc_sev | input | 26 | Uncorrectable severity (1 = fatal) |
| i_cor_mask | input | 16 | Correctable mask |
| i_cor_en | input | 1 | Correctable reporting enable |
| i_nf_en | input | 1 | Non-fatal reporting enable |
| i_fatal_en | input | 1 | Fatal reporting enable |
| i_ur_en | input | 1 | Unsupported-request reporting enable |
| i_serr_en | input | 1 | Command system-error enable |
| i_brg_serr_en | input | 1 | Bridge system-error forwarding enable |
| i_log_full | input | 1 | Header log has no free entry |
| o_devsta_set | output | 4 | Device status set: 0 corr, 1 non-fatal, 2 fatal, 3 unsupported request |
| o_cor_set | output | 16 | Correctable status set bits |
| o_unc_set | output | 26 | Uncorrectable status set bits |
| o_log_req | output | 1 | Header log request |
| o_sig_serr | output | 1 | Signalled system error set |
| o_rcv_serr | output | 1 | Bridge received system error set |
| o_msg_vld | output | 2 | Message emitted per lane |
| o_msg_sev | output | 4 | Message severity per lane |
| o_fwd_vld | output | 2 | Message forwarded past the bridge per lane |

## Verification
The bench builds the unit with its fixed 26-bit uncorrectable and 16-bit correctable code widths. It sweeps all 8192 combinations of the thirteen control choices for seven representative codes: a default-fatal code, a default-non-fatal code, the unsupported request, the flow-control code, and three correctable codes including the advisory and overflow positions. This covers every advisory, masking, unsupported-request and serr/enable interaction. A strided sweep then drives every code position as both correctable and uncorrectable, which reaches the unsupported-position rejection. Directed zero and two-hot codes complete the R1 rejection checks.

// File: rtl/err_report_pkg.sv
package err_report_pkg;

  localparam int UNC_W = 26;
  localparam int COR_W = 16;
  localparam int DS_W  = 4;

  // uncorrectable code positions the logic depends on
  localparam int UB_TRAIN  = 0;
  localparam int UB_DLP    = 4;
  localparam int UB_SDN    = 5;
  localparam int UB_POISON = 12;
  localparam int UB_FCP    = 13;
  localparam int UB_RXOVF  = 17;
  localparam int UB_MALF   = 18;
  localparam int UB_UR     = 20;

  // correctable code positions
  localparam int CB_RCVR   = 0;
  localparam int CB_BADTLP = 6;
  localparam int CB_ROLL   = 8;
  localparam int CB_TIMER  = 12;
  localparam int CB_ADVNF  = 13;
  localparam int CB_HLOVF  = 15;

  // device status set positions
  localparam int DS_CED  = 0;
  localparam int DS_NFED = 1;
  localparam int DS_FED  = 2;
  localparam int DS_URD  = 3;

  typedef enum logic [1:0] {
    SEV_NONE  = 2'd0,
    SEV_COR   = 2'd1,
    SEV_NF    = 2'd2,
    SEV_FATAL = 2'd3
  } sev_e;

  typedef struct packed {
    logic cor_en;
    logic nf_en;
    logic fatal_en;
    logic ur_en;
    logic serr_en;
    logic brg_serr_en;
  } enables_t;

  typedef struct packed {
    logic [DS_W-1:0]  devsta;
    logic [COR_W-1:0] cor;
    logic [UNC_W-1:0] unc;
    logic             log_req;
    logic             msg;
    sev_e             sev;
  } verdict_t;

  function automatic logic [UNC_W-1:0] unc_supported();
    logic [UNC_W-1:0] m;
    for (int i = 0; i < UNC_W; i++)
      m[i] = (i == UB_TRAIN) || (i == UB_DLP) || (i == UB_SDN) || (i >= UB_POISON);
    return m;
  endfunction

  function automatic logic [COR_W-1:0] cor_supported();
    logic [COR_W-1:0] m;
    for (int i = 0; i < COR_W; i++)
      m[i] = (i == CB_RCVR) || (i >= CB_BADTLP && i <= CB_ROLL) || (i >= CB_TIMER);
    return m;
  endfunction

  function automatic logic [UNC_W-1:0] default_fatal();
    logic [UNC_W-1:0] m;
    m = '0;
    m[UB_TRAIN] = 1'b1;
    m[UB_DLP]   = 1'b1;
    m[UB_SDN]   = 1'b1;
    m[UB_FCP]   = 1'b1;
    m[UB_RXOVF] = 1'b1;
    m[UB_MALF]  = 1'b1;
    return m;
  endfunction

  function automatic logic sev_enabled(sev_e s, enables_t e);
    case (s)
      SEV_COR:   return e.cor_en;
      SEV_NF:    return e.nf_en;
      SEV_FATAL: return e.fatal_en;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/err_decide.sv
module err_decide
  import err_report_pkg::*;
(
  input  logic             valid,
  input  logic             corr,
  input  logic             adv,
  input  logic             sev_src,
  input  logic [UNC_W-1:0] err,
  input  logic [UNC_W-1:0] unc_mask,
  input  logic [UNC_W-1:0] unc_sev,
  input  logic [COR_W-1:0] cor_mask,
  input  enables_t         en,
  output logic             accepted,
  output verdict_t         vd
);
  localparam int PAD_W = UNC_W - COR_W;

  logic [UNC_W-1:0] filt;
  logic             is_ur;
  logic             is_fatal;
  logic             unc_masked;
  logic             cor_masked;

  assign filt       = err & (corr ? {{PAD_W{1'b0}}, cor_supported()} : unc_supported());
  assign accepted   = valid && $onehot(filt);
  assign is_ur      = !corr && filt[UB_UR];
  assign is_fatal   = |(filt & (sev_src ? unc_sev : default_fatal()));
  assign unc_masked = |(filt & unc_mask);
  assign cor_masked = |(filt[COR_W-1:0] & cor_mask);

  always_comb begin
    vd     = '0;
    vd.sev = SEV_NONE;
    if (accepted) begin
      if (corr) begin
        vd.devsta[DS_CED] = 1'b1;
        vd.cor            = filt[COR_W-1:0];
        if (!cor_masked && en.cor_en) begin
          vd.msg = 1'b1;
          vd.sev = SEV_COR;
        end
      end else if (!is_fatal && adv) begin
        // advisory non-fatal: signalled as a correctable error
        vd.devsta[DS_CED] = 1'b1;
        vd.devsta[DS_URD] = is_ur;
        vd.cor[CB_ADVNF]  = 1'b1;
        if (!cor_mask[CB_ADVNF]) begin
          if (!unc_masked) begin
            vd.log_req = 1'b1;
            vd.unc     = filt;
          end
          if ((!is_ur || en.ur_en) && en.cor_en) begin
            vd.msg = 1'b1;
            vd.sev = SEV_COR;
          end
        end
      end else begin
        vd.devsta[DS_FED]  = is_fatal;
        vd.devsta[DS_NFED] = !is_fatal;
        vd.devsta[DS_URD]  = is_ur;
        vd.unc             = filt;
        if (!unc_masked) begin
          vd.log_req = 1'b1;
          if (!(is_ur && !en.ur_en && !en.serr_en)) begin
            if (is_fatal && (en.serr_en || en.fatal_en)) begin
              vd.msg = 1'b1;
              vd.sev = SEV_FATAL;
            end else if (!is_fatal && (en.serr_en || en.nf_en)) begin
              vd.msg = 1'b1;
              vd.sev = SEV_NF;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/err_hop.sv
module err_hop
  import err_report_pkg::*;
(
  input  logic     msg_in,
  input  sev_e     sev,
  input  enables_t en,
  output logic     sig_serr,
  output logic     emit,
  output logic     rcv_serr,
  output logic     fwd
);
  logic uncor;

  assign uncor    = (sev == SEV_NF) || (sev == SEV_FATAL);
  // device stage: serr marks the signalled bit, devctl then gates
  assign sig_serr = msg_in && uncor && en.serr_en;
  assign emit     = msg_in && (!(uncor && en.serr_en) || sev_enabled(sev, en));
  // bridge stage: one hop upstream
  assign rcv_serr = emit && uncor;
  assign fwd      = emit && en.brg_serr_en;

endmodule

// File: rtl/err_report_unit.sv
module err_report_unit
  import err_report_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_inj,
  input  logic             i_corr,
  input  logic             i_adv,
  input  logic [UNC_W-1:0] i_err,
  input  logic             i_sev_src,
  input  logic [UNC_W-1:0] i_unc_mask,
  input  logic [UNC_W-1:0] i_unc_sev,
  input  logic [COR_W-1:0] i_cor_mask,
  input  logic             i_cor_en,
  input  logic             i_nf_en,
  input  logic             i_fatal_en,
  input  logic             i_ur_en,
  input  logic             i_serr_en,
  input  logic             i_brg_serr_en,
  input  logic             i_log_full,
  output logic [DS_W-1:0]  o_devsta_set,
  output logic [COR_W-1:0] o_cor_set,
  output logic [UNC_W-1:0] o_unc_set,
  output logic             o_log_req,
  output logic             o_sig_serr,
  output logic             o_rcv_serr,
  output logic [1:0]       o_msg_vld,
  output logic [3:0]       o_msg_sev,
  output logic [1:0]       o_fwd_vld
);
  localparam int NLANE = 2;

  enables_t en;
  assign en = '{cor_en: i_cor_en, nf_en: i_nf_en, fatal_en: i_fatal_en,
                ur_en: i_ur_en, serr_en: i_serr_en, brg_serr_en: i_brg_serr_en};

  logic             l_valid [NLANE];
  logic             l_corr  [NLANE];
  logic             l_adv   [NLANE];
  logic [UNC_W-1:0] l_err   [NLANE];
  logic             l_acc   [NLANE];
  verdict_t         l_vd    [NLANE];
  logic             l_sig   [NLANE];
  logic             l_emit  [NLANE];
  logic             l_rcv   [NLANE];
  logic             l_fwd   [NLANE];

  // named event: the header log overflows and a follow-up is raised
  logic overflow_evt;
  assign overflow_evt = l_vd[0].log_req && i_log_full;

  for (genvar p = 0; p < NLANE; p++) begin : g_lane
    if (p == 0) begin : g_primary
      assign l_valid[p] = i_inj;
      assign l_corr[p]  = i_corr;
      assign l_adv[p]   = i_adv;
      assign l_err[p]   = i_err;
    end else begin : g_followup
      assign l_valid[p] = overflow_evt;
      assign l_corr[p]  = 1'b1;
      assign l_adv[p]   = 1'b0;
      assign l_err[p]   = UNC_W'(1) << CB_HLOVF;
    end

    err_decide u_decide (
      .valid    (l_valid[p]),
      .corr     (l_corr[p]),
      .adv      (l_adv[p]),
      .sev_src  (i_sev_src),
      .err      (l_err[p]),
      .unc_mask (i_unc_mask),
      .unc_sev  (i_unc_sev),
      .cor_mask (i_cor_mask),
      .en       (en),
      .accepted (l_acc[p]),
      .vd       (l_vd[p])
    );

    err_hop u_hop (
      .msg_in   (l_vd[p].msg),
      .sev      (l_vd[p].sev),
      .en       (en),
      .sig_serr (l_sig[p]),
      .emit     (l_emit[p]),
      .rcv_serr (l_rcv[p]),
      .fwd      (l_fwd[p])
    );
  end

  // the follow-up lane is only ever fed a supported single code
  logic lane1_dropped;
  assign lane1_dropped = l_valid[1] && !l_acc[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_devsta_set <= '0;
      o_cor_set    <= '0;
      o_unc_set    <= '0;
      o_log_req    <= 1'b0;
      o_sig_serr   <= 1'b0;
      o_rcv_serr   <= 1'b0;
      o_msg_vld    <= '0;
      o_msg_sev    <= '0;
      o_fwd_vld    <= '0;
    end else begin
      o_devsta_set <= l_vd[0].devsta | l_vd[1].devsta;
      o_cor_set    <= l_vd[0].cor | l_vd[1].cor;
      o_unc_set    <= l_vd[0].unc | l_vd[1].unc;
      o_log_req    <= l_vd[0].log_req | l_vd[1].log_req;
      o_sig_serr   <= l_sig[0] | l_sig[1];
      o_rcv_serr   <= l_rcv[0] | l_rcv[1];
      o_msg_vld    <= {l_emit[1], l_emit[0]};
      o_msg_sev    <= {(l_emit[1] ? l_vd[1].sev : SEV_NONE),
                       (l_emit[0] ? l_vd[0].sev : SEV_NONE)};
      o_fwd_vld    <= {l_fwd[1], l_fwd[0]};
    end
  end

  // ---------------- assertions ----------------
  assert_no_msg_without_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (o_msg_vld != 2'b00) |-> $past(i_inj));

  assert_unc_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(o_unc_set) <= 1);

  assert_followup_accepted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lane1_dropped);

  assert_sev_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(o_devsta_set[DS_FED:DS_NFED]));

  assert_fatal_needs_devctl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (o_msg_vld[0] && o_msg_sev[1:0] == SEV_FATAL) |-> $past(i_fatal_en));

  assert_sig_needs_serr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    o_sig_serr |-> $past(i_serr_en));

  assert_fwd_implies_msg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (o_fwd_vld & ~o_msg_vld) == 2'b00);

  assert_rcv_uncor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    o_rcv_serr |-> (o_msg_vld[0] && o_msg_sev[1:0] != SEV_COR));

  assert_followup_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    o_msg_vld[1] |-> (o_log_req && o_msg_sev[3:2] == SEV_COR && $past(i_log_full)));

endmodule

// File: tb/err_report_unit_bench.sv
module err_report_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;
  localparam logic [25:0] UNC_SUP   = 26'h3FFF031;
  localparam logic [15:0] COR_SUP   = 16'hF1C1;
  localparam logic [25:0] DEF_FATAL = 26'h0062031;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic i_inj = 0, i_corr = 0, i_adv = 0, i_sev_src = 0;
  logic [25:0] i_err = '0, i_unc_mask = '0, i_unc_sev = '0;
  logic [15:0] i_cor_mask = '0;
  logic i_cor_en = 0, i_nf_en = 0, i_fatal_en = 0, i_ur_en = 0;
  logic i_serr_en = 0, i_brg_serr_en = 0, i_log_full = 0;
  logic [3:0]  o_devsta_set;
  logic [15:0] o_cor_set;
  logic [25:0] o_unc_set;
  logic o_log_req, o_sig_serr, o_rcv_serr;
  logic [1:0] o_msg_vld, o_fwd_vld;
  logic [3:0] o_msg_sev;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expected values
  logic [3:0]  e_ds;
  logic [15:0] e_cor;
  logic [25:0] e_unc;
  logic e_log, e_sig, e_rcv;
  logic [1:0] e_mv, e_fv;
  logic [3:0] e_ms;
  string tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_report_unit u_err_report_unit (
    .clk(clk), .rst_n(rst_n), .i_inj(i_inj), .i_corr(i_corr), .i_adv(i_adv),
    .i_err(i_err), .i_sev_src(i_sev_src), .i_unc_mask(i_unc_mask),
    .i_unc_sev(i_unc_sev), .i_cor_mask(i_cor_mask), .i_cor_en(i_cor_en),
    .i_nf_en(i_nf_en), .i_fatal_en(i_fatal_en), .i_ur_en(i_ur_en),
    .i_serr_en(i_serr_en), .i_brg_serr_en(i_brg_serr_en), .i_log_full(i_log_full),
    .o_devsta_set(o_devsta_set), .o_cor_set(o_cor_set), .o_unc_set(o_unc_set),
    .o_log_req(o_log_req), .o_sig_serr(o_sig_serr), .o_rcv_serr(o_rcv_serr),
    .o_msg_vld(o_msg_vld), .o_msg_sev(o_msg_sev), .o_fwd_vld(o_fwd_vld)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h (corr=%0d adv=%0d err=%h)",
               req, what, act, exp, i_corr, i_adv, i_err);
    end
  endtask

  // one hop of a message: device gating, then bridge
  task automatic hop(input int p, input bit ok, input logic [1:0] s);
    bit unc, en, pass;
    if (!ok) return;
    unc = (s != 2'd1);
    en  = (s == 2'd1) ? i_cor_en : (s == 2'd2) ? i_nf_en : i_fatal_en;
    if (unc && i_serr_en) e_sig = 1'b1;
    pass = !(unc && i_serr_en) || en;
    if (pass) begin
      e_mv[p] = 1'b1;
      e_ms[2*p +: 2] = s;
      if (unc) e_rcv = 1'b1;
      e_fv[p] = i_brg_serr_en;
    end
  endtask

  task automatic model();
    logic [25:0] f;
    bit ur, fat, ok0, ok1;
    logic [1:0] s0;
    e_ds = '0; e_cor = '0; e_unc = '0; e_log = 0; e_sig = 0; e_rcv = 0;
    e_mv = '0; e_fv = '0; e_ms = '0;
    tag = "R1";
    f = i_corr ? (i_err & {10'b0, COR_SUP}) : (i_err & UNC_SUP);
    if (f == '0 || (f & (f - 26'd1)) != '0) return;
    ok0 = 0; s0 = 2'd0;
    ur = !i_corr && (f == (26'd1 << 20));
    if (i_corr) begin
      tag = "R3";
      e_ds[0] = 1'b1;
      e_cor = f[15:0];
      if ((i_cor_mask & f[15:0]) == '0 && i_cor_en) begin ok0 = 1; s0 = 2'd1; end
    end else begin
      fat = i_sev_src ? ((i_unc_sev & f) != '0) : ((DEF_FATAL & f) != '0);
      if (!fat && i_adv) begin
        tag = "R4";
        e_ds[0] = 1'b1;
        if (ur) e_ds[3] = 1'b1;
        e_cor[13] = 1'b1;
        if (!i_cor_mask[13]) begin
          if ((i_unc_mask & f) == '0) begin e_log = 1; e_unc = f; end
          if ((!ur || i_ur_en) && i_cor_en) begin ok0 = 1; s0 = 2'd1; end
        end
      end else begin
        tag = i_sev_src ? "R5" : "R2";
        if (fat) e_ds[2] = 1'b1; else e_ds[1] = 1'b1;
        if (ur) e_ds[3] = 1'b1;
        e_unc = f;
        if ((i_unc_mask & f) == '0) begin
          e_log = 1;
          if (!(ur && !i_ur_en && !i_serr_en)) begin
            if (fat && (i_serr_en || i_fatal_en)) begin ok0 = 1; s0 = 2'd3; end
            if (!fat && (i_serr_en || i_nf_en)) begin ok0 = 1; s0 = 2'd2; end
          end
        end
      end
    end
    hop(0, ok0, s0);
    if (e_log && i_log_full) begin
      e_ds[0] = 1'b1;
      e_cor[15] = 1'b1;
      ok1 = !i_cor_mask[15] && i_cor_en;
      hop(1, ok1, 2'd1);
    end
  endtask

  task automatic compare();
    chk(o_devsta_set == e_ds, tag, "devsta", 32'(o_devsta_set), 32'(e_ds));
    chk(o_cor_set == e_cor, tag, "cor_set", 32'(o_cor_set), 32'(e_cor));
    chk(o_unc_set == e_unc, tag, "unc_set", 32'(o_unc_set), 32'(e_unc));
    chk(o_log_req == e_log, tag, "log_req", 32'(o_log_req), 32'(e_log));
    chk(o_msg_vld[0] == e_mv[0] && o_msg_sev[1:0] == e_ms[1:0], "R6", "msg0",
        {o_msg_sev[1:0], o_msg_vld[0]}, {e_ms[1:0], e_mv[0]});
    chk(o_sig_serr == e_sig, "R7", "sig_serr", 32'(o_sig_serr), 32'(e_sig));
    chk(o_rcv_serr == e_rcv && o_fwd_vld[0] == e_fv[0], "R8", "rcv/fwd0",
        {o_rcv_serr, o_fwd_vld[0]}, {e_rcv, e_fv[0]});
    chk(o_msg_vld[1] == e_mv[1] && o_msg_sev[3:2] == e_ms[3:2] && o_fwd_vld[1] == e_fv[1],
        "R9", "lane1", {o_fwd_vld[1], o_msg_sev[3:2], o_msg_vld[1]},
        {e_fv[1], e_ms[3:2], e_mv[1]});
  endtask

  // at a negedge: strobe, then check at the following negedge
  task automatic run_vec();
    model();
    i_inj = 1'b1;
    @(negedge clk);
    i_inj = 1'b0;
    compare();
  endtask

  task automatic set_cfg(input int c);
    i_unc_mask    = c[0] ? '1 : '0;
    i_unc_sev     = c[1] ? '1 : '0;
    i_sev_src     = c[2];
    i_adv         = c[3];
    i_cor_mask    = (c[5] ? 16'h7FFF : 16'h0000) | (c[4] ? 16'h8000 : 16'h0000);
    i_cor_en      = c[6];
    i_nf_en       = c[7];
    i_fatal_en    = c[8];
    i_ur_en       = c[9];
    i_serr_en     = c[10];
    i_brg_serr_en = c[11];
    i_log_full    = c[12];
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state R1
    chk(o_msg_vld == 2'b00 && o_devsta_set == 4'h0 && o_unc_set == '0 && !o_log_req,
        "R1", "reset", {o_msg_vld, o_devsta_set}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(o_msg_vld == 2'b00 && o_cor_set == '0, "R1", "idle", 32'(o_msg_vld), 32'h0);

    // directed R1 rejections: empty and two-hot codes
    set_cfg(8191);
    i_corr = 0; i_err = '0;                           run_vec();
    i_err = (26'd1 << 4) | (26'd1 << 5);             run_vec();
    i_corr = 1; i_err = (26'd1 << 6) | (26'd1 << 7); run_vec();

    // directed R2: default-table severity
    set_cfg(0); i_corr = 0; i_err = 26'd1 << 13; run_vec();
    i_err = 26'd1 << 12; run_vec();

    // full control sweep on representative codes (R2..R9)
    for (int k = 0; k < 7; k++) begin
      for (int c = 0; c < 8192; c++) begin
        set_cfg(c);
        case (k)
          0: begin i_corr = 0; i_err = 26'd1 << 4;  end
          1: begin i_corr = 0; i_err = 26'd1 << 12; end
          2: begin i_corr = 0; i_err = 26'd1 << 20; end
          3: begin i_corr = 0; i_err = 26'd1 << 13; end
          4: begin i_corr = 1; i_err = 26'd1 << 6;  end
          5: begin i_corr = 1; i_err = 26'd1 << 13; end
          default: begin i_corr = 1; i_err = 26'd1 << 15; end
        endcase
        run_vec();
      end
    end

    // every position, both kinds, strided controls (R1 supported sets)
    for (int b = 0; b < 26; b++) begin
      for (int k = 0; k < 2; k++) begin
        for (int c = 0; c < 8192; c += 37) begin
          set_cfg(c);
          i_corr = k[0];
          i_err = 26'd1 << b;
          run_vec();
        end
      end
    end

    @(negedge clk);
    chk(o_msg_vld == 2'b00 && o_devsta_set == 4'h0, "R1", "no strobe",
        {o_msg_vld, o_devsta_set}, 32'h0);
    done = 1;
    summary();
    $finish;
  end

endmodule